// File: doc/BRIEF.md
# Speculative Memory Version Buffer

This block sits between a group of in-order speculative threads and the memory below them. Each thread runs in one of four stages, and the stages are ordered from the oldest (the head) to the youngest. For every address that some thread has touched, the buffer keeps one entry. The entry holds a separate stored version of that location for each stage, along with a mark for each stage that has loaded it.

When a load arrives, the buffer returns the version written by the closest store at or before the loading stage. If no such store exists, it reports a miss, and the value must then come from memory. When a store arrives, the buffer scans the younger stages for a load that ran too early and reports the oldest offender on a violation output.

A commit input drains the head stage's stored versions to memory, one per cycle, and then retires the head. A squash input discards a stage and every stage younger than it. Memory and the re-execution of threads are left to the surrounding logic.

Top module: `spec_version_buffer`

## Requirements
- R1: At most one entry exists per address, and that entry keeps an independent data version per stage. A load from stage s that finds a store by s itself returns the data s stored, not another stage's version.
- R2: An accepted load raises `rsp_valid` on the next cycle. If any stage from the head up to and including the loading stage has stored to the address, `rsp_hit` is 1 and `rsp_data` is the version of the youngest such stage.
- R3: An accepted load with no store at or before its stage gives `rsp_valid`=1, `rsp_hit`=0 and `rsp_data`=0 on the next cycle. The caller then reads memory.
- R4: Every accepted load sets the load mark of its stage in the address's entry, whether it hits or misses. A new address allocates an entry.
- R5: An accepted store records its data as its stage's version. It then scans the younger stages in order, oldest first. The first stage that has a load mark ends the scan and is reported: `viol_valid`=1 and `viol_stage` set to that stage number, on the next cycle. A stage that has only a store mark ends the scan with no report. If the scan finds neither, `viol_valid`=0.
- R6: Stages are numbered 0 to 3. The order runs from `head` upward modulo 4, and the head is stage 0 after reset. With all 8 entries in use, a request for a new address sees `req_ready`=0 and changes nothing.
- R7: While `commit` is high, each cycle in which the head stage still has a stored version raises `mem_wr_valid` with that address and data and removes the version. In the first cycle with none left, `commit_done` is 1. At that edge every head mark is cleared and the head advances by one.
- R8: An entry with no load or store mark left is freed and can take a new address.
- R9: A one-cycle `squash` with stage q clears the marks and versions of q and of every stage younger than q.
- R10: `req_ready` is 0 while `commit` or `squash` is high. Squash takes priority over commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load/store request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | Store data |
| req_stage | input | 2 | Issuing stage number |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Load response present |
| rsp_hit | output | 1 | 1 = forwarded version, 0 = read memory |
| rsp_data | output | DATA_W | Forwarded data |
| viol_valid | output | 1 | Early load detected |
| viol_stage | output | 2 | Oldest stage that loaded too early |
| commit | input | 1 | Retire the head stage (held until done) |
| commit_done | output | 1 | Head retires at this edge |
| mem_wr_valid | output | 1 | Write of a head version to memory |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | DATA_W | Write data |
| squash | input | 1 | Discard a stage and younger ones |
| squash_stage | input | 2 | Oldest stage discarded |

## Verification
Some results are combinational and are due in the same cycle as their cause: `req_ready`, and during commit `mem_wr_valid`, `mem_wr_addr`, `mem_wr_data` and `commit_done`. The bench drives on the falling edge and reads these one time step later. The load response and the violation report pass through one register, so the bench reads them one time step after the rising edge that accepts the request. The bench lowers `req_valid` at that moment, which ensures no second request is accepted. A reference model kept per address predicts every hit, miss, violation, stall and write-back. The model walks the stage order differently from the design.

// File: rtl/svb_pkg.sv
package svb_pkg;
  localparam int STAGES = 4;             // power of two: order wraps modulo STAGES
  localparam int STG_W  = $clog2(STAGES);

  typedef logic [STG_W-1:0]  stage_t;
  typedef logic [STAGES-1:0] smask_t;
  typedef struct packed {
    logic   found;
    stage_t stage;
  } pick_t;

  // position of stage s counted from the head (0 = oldest)
  function automatic stage_t rel_of(stage_t s, stage_t head);
    return stage_t'(s - head);
  endfunction

  function automatic stage_t abs_of(stage_t r, stage_t head);
    return stage_t'(r + head);
  endfunction

  // youngest store at or before stage s
  function automatic pick_t fwd_pick(smask_t st, stage_t s, stage_t head);
    pick_t  p;
    stage_t t;
    p = '0;
    for (int r = 0; r < STAGES; r++) begin
      t = abs_of(stage_t'(r), head);
      if (stage_t'(r) <= rel_of(s, head) && st[t]) begin
        p.found = 1'b1;
        p.stage = t;
      end
    end
    return p;
  endfunction

  // oldest younger stage with a load mark, stopped by a younger store
  function automatic pick_t viol_scan(smask_t ld, smask_t st, stage_t s, stage_t head);
    pick_t  p;
    logic   stop;
    stage_t t;
    p    = '0;
    stop = 1'b0;
    for (int r = 0; r < STAGES; r++) begin
      t = abs_of(stage_t'(r), head);
      if (!stop && stage_t'(r) > rel_of(s, head)) begin
        if (ld[t]) begin
          p.found = 1'b1;
          p.stage = t;
          stop    = 1'b1;
        end else if (st[t]) begin
          stop = 1'b1;
        end
      end
    end
    return p;
  endfunction

  // stage q and every stage younger than it
  function automatic smask_t younger_mask(stage_t q, stage_t head);
    smask_t m;
    m = '0;
    for (int t = 0; t < STAGES; t++)
      if (rel_of(stage_t'(t), head) >= rel_of(q, head)) m[t] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/svb_prio.sv
module svb_prio #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) idx_o = IW'(i);
  end
  assign any_o = |req_i;
endmodule

// File: rtl/svb_entry.sv
module svb_entry
  import svb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     set_ld_i,
  input  logic                     set_st_i,
  input  stage_t                   stage_i,
  input  logic [DATA_W-1:0]        data_i,
  input  smask_t                   clr_ld_i,
  input  smask_t                   clr_st_i,
  output logic                     valid_o,
  output logic [ADDR_W-1:0]        addr_o,
  output smask_t                   ld_o,
  output smask_t                   st_o,
  output logic [STAGES*DATA_W-1:0] data_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  smask_t            ld_q, st_q, ld_n, st_n;
  logic [DATA_W-1:0] ver_q [STAGES];

  always_comb begin
    ld_n = (alloc_i ? '0 : ld_q) & ~clr_ld_i;
    st_n = (alloc_i ? '0 : st_q) & ~clr_st_i;
    if (set_ld_i) ld_n[stage_i] = 1'b1;
    if (set_st_i) st_n[stage_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      ld_q    <= '0;
      st_q    <= '0;
      for (int s = 0; s < STAGES; s++) ver_q[s] <= '0;
    end else begin
      valid_q <= alloc_i | (valid_q & ((|ld_n) | (|st_n)));
      if (alloc_i)  addr_q <= addr_i;
      ld_q <= ld_n;
      st_q <= st_n;
      if (set_st_i) ver_q[stage_i] <= data_i;
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_out
    assign data_o[s*DATA_W +: DATA_W] = ver_q[s];
  end
  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign ld_o    = ld_q;
  assign st_o    = st_q;
endmodule

// File: rtl/spec_version_buffer.sv
module spec_version_buffer
  import svb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        req_stage,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              viol_valid,
  output logic [1:0]        viol_stage,
  input  logic              commit,
  output logic              commit_done,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              squash,
  input  logic [1:0]        squash_stage
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  stage_t                   head_q;
  logic [NUM_ENTRIES-1:0]   ent_valid, match_vec, free_vec, wb_vec;
  logic [ADDR_W-1:0]        ent_addr [NUM_ENTRIES];
  smask_t                   ent_ld   [NUM_ENTRIES];
  smask_t                   ent_st   [NUM_ENTRIES];
  logic [STAGES*DATA_W-1:0] ent_data [NUM_ENTRIES];

  logic             hit, free_any, wb_any;
  logic [IDX_W-1:0] hit_idx, free_idx, wb_idx, tgt_idx;
  logic             busy, acc, ld_acc, st_acc, new_alloc;
  logic             commit_wb;
  smask_t           sel_ld, sel_st, sq_mask, head_mask;
  pick_t            fwd, viol;
  logic [DATA_W-1:0] fwd_data;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_vec
    assign match_vec[i] = ent_valid[i] && (ent_addr[i] == req_addr);
    assign free_vec[i]  = ~ent_valid[i];
    assign wb_vec[i]    = ent_valid[i] && ent_st[i][head_q];
  end

  svb_prio #(.N(NUM_ENTRIES), .IW(IDX_W)) u_match (.req_i(match_vec), .any_o(hit),      .idx_o(hit_idx));
  svb_prio #(.N(NUM_ENTRIES), .IW(IDX_W)) u_free  (.req_i(free_vec),  .any_o(free_any), .idx_o(free_idx));
  svb_prio #(.N(NUM_ENTRIES), .IW(IDX_W)) u_wb    (.req_i(wb_vec),    .any_o(wb_any),   .idx_o(wb_idx));

  // request side
  assign busy      = commit | squash;
  assign req_ready = !busy && (hit || free_any);
  assign acc       = req_valid && req_ready;
  assign ld_acc    = acc && !req_store;
  assign st_acc    = acc && req_store;
  assign new_alloc = acc && !hit;
  assign tgt_idx   = hit ? hit_idx : free_idx;
  assign sel_ld    = hit ? ent_ld[hit_idx] : '0;
  assign sel_st    = hit ? ent_st[hit_idx] : '0;
  assign fwd       = fwd_pick(sel_st, req_stage, head_q);
  assign viol      = viol_scan(sel_ld, sel_st, req_stage, head_q);
  assign fwd_data  = ent_data[hit_idx][fwd.stage*DATA_W +: DATA_W];

  // retire / discard side
  assign commit_wb    = commit && !squash && wb_any;
  assign commit_done  = commit && !squash && !wb_any;
  assign mem_wr_valid = commit_wb;
  assign mem_wr_addr  = ent_addr[wb_idx];
  assign mem_wr_data  = ent_data[wb_idx][head_q*DATA_W +: DATA_W];
  assign sq_mask      = younger_mask(squash_stage, head_q);
  assign head_mask    = smask_t'(1) << head_q;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic   alloc_e, set_ld_e, set_st_e;
    smask_t clr_ld_e, clr_st_e;
    assign alloc_e  = new_alloc && (free_idx == IDX_W'(i));
    assign set_ld_e = ld_acc && (tgt_idx == IDX_W'(i));
    assign set_st_e = st_acc && (tgt_idx == IDX_W'(i));
    assign clr_ld_e = squash ? sq_mask : (commit_done ? head_mask : '0);
    assign clr_st_e = squash ? sq_mask :
                      (commit_done || (commit_wb && wb_idx == IDX_W'(i))) ? head_mask : '0;

    svb_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_i  (alloc_e),
      .addr_i   (req_addr),
      .set_ld_i (set_ld_e),
      .set_st_i (set_st_e),
      .stage_i  (req_stage),
      .data_i   (req_data),
      .clr_ld_i (clr_ld_e),
      .clr_st_i (clr_st_e),
      .valid_o  (ent_valid[i]),
      .addr_o   (ent_addr[i]),
      .ld_o     (ent_ld[i]),
      .st_o     (ent_st[i]),
      .data_o   (ent_data[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_data   <= '0;
      viol_valid <= 1'b0;
      viol_stage <= '0;
    end else begin
      rsp_valid  <= ld_acc;
      rsp_hit    <= ld_acc && fwd.found;
      rsp_data   <= (ld_acc && fwd.found) ? fwd_data : '0;
      viol_valid <= st_acc && viol.found;
      viol_stage <= viol.stage;
      if (commit_done) head_q <= head_q + 1'b1;
    end
  end
endmodule

// File: rtl/svb_checker.sv
module svb_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_ready,
  input logic         commit,
  input logic         squash,
  input logic         ld_acc,
  input logic         st_acc,
  input logic         rsp_valid,
  input logic         viol_valid,
  input logic         mem_wr_valid,
  input logic         commit_done,
  input logic [1:0]   head_q,
  input logic [N-1:0] match_vec
);
  assert_one_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  assert_rsp_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_acc |=> rsp_valid);

  assert_rsp_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(ld_acc));

  assert_viol_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(st_acc));

  assert_wb_in_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (commit && !commit_done));

  assert_head_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q != $past(head_q)) |-> $past(commit_done));

  assert_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || squash) |-> !req_ready);
endmodule

bind spec_version_buffer svb_checker #(.N(NUM_ENTRIES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .commit       (commit),
  .squash       (squash),
  .ld_acc       (ld_acc),
  .st_acc       (st_acc),
  .rsp_valid    (rsp_valid),
  .viol_valid   (viol_valid),
  .mem_wr_valid (mem_wr_valid),
  .commit_done  (commit_done),
  .head_q       (head_q),
  .match_vec    (match_vec)
);

// File: tb/spec_version_buffer_tb_top.sv
module spec_version_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NADDR      = 12;
  localparam int CAP        = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store;
  logic [15:0] req_addr;
  logic [31:0] req_data;
  logic [1:0]  req_stage;
  logic        req_ready;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_data;
  logic        viol_valid;
  logic [1:0]  viol_stage;
  logic        commit, commit_done, mem_wr_valid;
  logic [15:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic        squash;
  logic [1:0]  squash_stage;

  int errors = 0;
  int checks = 0;

  // reference model, kept per address slot
  bit          m_ld  [NADDR][4];
  bit          m_st  [NADDR][4];
  logic [31:0] m_dat [NADDR][4];
  int          m_head = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_version_buffer dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_store(req_store), .req_addr(req_addr),
    .req_data(req_data), .req_stage(req_stage), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .viol_valid(viol_valid), .viol_stage(viol_stage),
    .commit(commit), .commit_done(commit_done), .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .squash(squash), .squash_stage(squash_stage)
  );

  function automatic logic [15:0] addr_of(int k);
    return 16'h0100 + 16'(k * 16);
  endfunction

  function automatic int age(int s);
    return (s - m_head + 4) % 4;
  endfunction

  function automatic bit live(int k);
    bit any = 0;
    for (int s = 0; s < 4; s++) any |= m_ld[k][s] | m_st[k][s];
    return any;
  endfunction

  function automatic int live_count();
    int n = 0;
    for (int k = 0; k < NADDR; k++) if (live(k)) n++;
    return n;
  endfunction

  // walk backwards from the loading stage toward the head
  function automatic bit ref_fwd(int k, int s, output logic [31:0] d);
    d = '0;
    for (int back = 0; back <= age(s); back++) begin
      int t = (s - back + 4) % 4;
      if (m_st[k][t]) begin
        d = m_dat[k][t];
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  // walk forward from the storing stage toward the youngest
  function automatic bit ref_viol(int k, int s, output int who);
    who = 0;
    for (int step = 1; step <= 3 - age(s); step++) begin
      int t = (s + step) % 4;
      if (m_ld[k][t]) begin
        who = t;
        return 1'b1;
      end
      if (m_st[k][t]) return 1'b0;
    end
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_op(input bit st, input int k, input int s, input logic [31:0] d);
    bit          exp_ready, exp_hit, exp_v;
    logic [31:0] exp_d;
    int          exp_who;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_addr = addr_of(k);
    req_data = d; req_stage = 2'(s);
    exp_ready = live(k) || (live_count() < CAP);
    exp_hit   = ref_fwd(k, s, exp_d);
    exp_v     = ref_viol(k, s, exp_who);
    #1;
    chk(req_ready == exp_ready, "R6 req_ready", req_ready, exp_ready);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    if (!exp_ready) begin
      chk(!rsp_valid && !viol_valid, "R6 stalled request ignored", {rsp_valid, viol_valid}, 0);
    end else if (!st) begin
      chk(rsp_valid == 1'b1, "R2 rsp_valid", rsp_valid, 1);
      chk(rsp_hit == exp_hit, exp_hit ? "R2 rsp_hit" : "R3 rsp_hit", rsp_hit, exp_hit);
      chk(rsp_data == exp_d, exp_hit ? "R2 rsp_data" : "R3 rsp_data", rsp_data, exp_d);
      m_ld[k][s] = 1'b1;                                        // R4
    end else begin
      chk(!rsp_valid, "R5 no response to store", rsp_valid, 0);
      chk(viol_valid == exp_v, "R5 viol_valid", viol_valid, exp_v);
      if (exp_v) chk(viol_stage == 2'(exp_who), "R5 viol_stage", viol_stage, exp_who);
      m_st[k][s]  = 1'b1;
      m_dat[k][s] = d;
    end
  endtask

  task automatic do_commit();
    int guard = 0;
    @(negedge clk);
    commit = 1'b1;
    forever begin
      bit pend = 0;
      #1;
      guard++;
      chk(!req_ready, "R10 blocked in commit", req_ready, 0);
      for (int k = 0; k < NADDR; k++) pend |= m_st[k][m_head];
      if (commit_done || guard > 20) begin
        chk(!pend && commit_done, "R7 commit_done after drain", commit_done, !pend);
        for (int k = 0; k < NADDR; k++) begin
          m_ld[k][m_head] = 1'b0;
          m_st[k][m_head] = 1'b0;
        end
        m_head = (m_head + 1) % 4;
        @(posedge clk);
        #1;
        commit = 1'b0;
        break;
      end else begin
        int hitk = -1;
        chk(mem_wr_valid == pend, "R7 mem_wr_valid", mem_wr_valid, pend);
        for (int k = 0; k < NADDR; k++) if (addr_of(k) == mem_wr_addr) hitk = k;
        if (hitk < 0 || !m_st[hitk][m_head]) begin
          chk(1'b0, "R7 mem_wr_addr", mem_wr_addr, 0);
        end else begin
          chk(mem_wr_data == m_dat[hitk][m_head], "R7 mem_wr_data", mem_wr_data, m_dat[hitk][m_head]);
          m_st[hitk][m_head] = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
      end
    end
  endtask

  task automatic do_squash(input int q);
    int qa;
    @(negedge clk);
    squash = 1'b1;
    squash_stage = 2'(q);
    #1;
    chk(!req_ready, "R10 blocked in squash", req_ready, 0);
    @(posedge clk);
    #1;
    squash = 1'b0;
    qa = age(q);
    for (int t = 0; t < 4; t++)
      if (age(t) >= qa)
        for (int k = 0; k < NADDR; k++) begin
          m_ld[k][t] = 1'b0;
          m_st[k][t] = 1'b0;
        end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_addr = '0;
    req_data = '0; req_stage = '0; commit = 1'b0; squash = 1'b0; squash_stage = '0;
    for (int k = 0; k < NADDR; k++)
      for (int s = 0; s < 4; s++) begin
        m_ld[k][s] = 0; m_st[k][s] = 0; m_dat[k][s] = '0;
      end
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !viol_valid && !mem_wr_valid,
        "R6 reset state", {req_ready, rsp_valid, viol_valid, mem_wr_valid}, 4'b1000);

    // R1: per-stage versions of one address
    do_op(1, 0, 0, 32'hAAAA_0000);
    do_op(1, 0, 1, 32'hBBBB_1111);
    do_op(0, 0, 1, 0);              // own version
    do_op(0, 0, 0, 0);              // older version only
    do_op(0, 0, 3, 0);              // youngest store at or before
    // R3: miss
    do_op(0, 1, 2, 0);
    // R5: masking by a younger store, then a real violation
    do_op(1, 1, 1, 32'h1234);       // stage 2 loaded: report 2
    do_op(1, 2, 2, 32'h55);
    do_op(0, 2, 3, 0);
    do_op(1, 2, 0, 32'h66);         // stage 2 store masks stage 3
    do_op(0, 3, 1, 0);
    do_op(0, 3, 3, 0);
    do_op(1, 3, 0, 32'h77);         // oldest offender is stage 1
    // R6 / R8: fill, stall, free by squash
    for (int k = 4; k < NADDR; k++) do_op(0, k, 2, 0);
    do_squash(m_head);              // R9: everything discarded
    do_op(0, 11, 0, 0);             // R8: freed entries reusable
    // R7: commit drains
    do_op(1, 5, 0, 32'hC0FFEE);
    do_op(1, 6, 0, 32'hBEEF);
    do_commit();
    do_commit();

    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 100;
      if (r < 76)      do_op(($urandom % 100) < 40, $urandom % 10, $urandom % 4, $urandom);
      else if (r < 90) do_commit();
      else             do_squash($urandom % 4);
    end

    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule